// File: doc/BRIEF.md
# SD SPI-Mode Command Framer

This block sends one SD-card command over an SPI byte engine and collects the card's reply. A start strobe captures three fields: a 6-bit command index, a 32-bit argument and a trailing byte. The trailing byte already holds the checksum and the end bit, because this block does not compute a checksum. The framer then hands six bytes to the byte engine, one at a time. The first byte is the index with the start/transmission prefix 0x40 added. The next four are the argument, most significant byte first. The last is the trailing byte.

After the frame, the framer keeps the link clocked by sending 0xFF filler bytes. It takes the first received byte whose top bit is clear as the card's reply. If the card stays silent for a set number of filler bytes, the framer raises a timeout flag instead. Either outcome is reported with a one-clock done pulse.

Every byte the engine returns is also classified against the three data tokens that frame 512-byte blocks:
- 0xFE starts a single-block read or write.
- 0xFC starts a multi-block write.
- 0xFD stops a transfer.

Higher-level logic can use this classification when it moves block payloads.

Top module: `sd_cmd_framer`

## Requirements
- R1: After reset, busy, tx_valid, done and timeout are 0 and token_kind is 0 (no token).
- R2: The first byte of each frame is 0x40 plus the captured 6-bit index, so bits 7:6 are 01 and bits 5:0 are the index.
- R3: Frame bytes two to five carry the captured argument, bits 31:24 first and bits 7:0 last.
- R4: The sixth frame byte is the captured trailing byte, unchanged.
- R5: Once the frame is sent, every further byte sent is 0xFF. While tx_valid is high and tx_ready is low, tx_valid stays high and tx_byte does not change.
- R6: The reply is the first byte received after a filler byte whose bit 7 is 0. Bytes received while the six frame bytes are being sent are never taken as the reply, whatever their value. A valid reply comes with timeout = 0.
- R7: If POLL_MAX filler bytes (default 8) all return a byte with bit 7 set, the framer stops. It then reports timeout = 1, resp = the last received byte, and a done pulse.
- R8: done is high for exactly one clock, and busy is already low in that clock.
- R9: A start strobe while busy is ignored. The frame in progress keeps its captured fields, and no second command follows.
- R10: token_kind updates on each received byte: 1 for 0xFE, 2 for 0xFC, 3 for 0xFD, 0 for any other value. It holds its value between received bytes.
- R11: Only one byte is outstanding at a time. After a byte is accepted, tx_valid stays low until the engine returns the byte received in exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Strobe that begins a command when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_tail | input | 8 | Trailing byte (checksum and end bit) |
| busy | output | 1 | A command is in progress |
| tx_valid | output | 1 | A byte is offered to the byte engine |
| tx_ready | input | 1 | The byte engine takes the offered byte |
| tx_byte | output | 8 | Byte offered to the engine |
| rx_valid | input | 1 | The engine returns the byte received in exchange |
| rx_byte | input | 8 | Byte received from the card |
| done | output | 1 | One-clock pulse when reply or timeout is reported |
| resp | output | 8 | Reply byte (or last received byte on timeout) |
| timeout | output | 1 | The last command timed out |
| token_kind | output | 2 | Class of the most recent received byte |

## Verification
The assertions assume the byte engine returns exactly one rx_valid pulse for each accepted byte, and only while the framer is waiting for it. They also assume rx_valid never arrives in the same cycle as tx_valid. The bench's engine model keeps to this. It logs each accepted byte, answers it with one rx_valid pulse on the following cycle, and holds tx_ready low on alternate cycles in some runs. In those runs the hold rule is exercised with stalls. The bench sweeps:
- eight command indices;
- every reply position from the first to the last filler byte, plus silence;
- a set of filler values that covers each token and near-miss values.

// File: rtl/sd_frm_pkg.sv
// Shared types and constants for the SD command framer.
// Assumes byte-wide SPI transfers and a fixed six-byte command frame.
package sd_frm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT
    } frm_state_t;

    typedef enum logic [1:0] {
        TOK_NONE   = 2'd0,
        TOK_SINGLE = 2'd1,
        TOK_MULTI  = 2'd2,
        TOK_STOP   = 2'd3
    } tok_kind_t;

    localparam int          FRAME_LEN     = 6;
    localparam int          BLOCK_BYTES   = 512;
    localparam logic [7:0]  CMD_PREFIX    = 8'h40;
    localparam logic [7:0]  FILL_BYTE     = 8'hFF;
    localparam logic [7:0]  TOKEN_SINGLE  = 8'hFE;
    localparam logic [7:0]  TOKEN_MULTI   = 8'hFC;
    localparam logic [7:0]  TOKEN_STOP    = 8'hFD;
endpackage

// File: rtl/sd_frame_mux.sv
// Selects the byte to send for a given frame position.
// Positions 0..5 are the command frame; any later position yields filler.
// Assumes the argument is a multiple of 8 bits wide.
module sd_frame_mux
    import sd_frm_pkg::*;
#(
    parameter int ARG_W = 32,
    parameter int POS_W = 3
) (
    input  logic [POS_W-1:0] pos,
    input  logic [5:0]       idx,
    input  logic [ARG_W-1:0] arg,
    input  logic [7:0]       tail,
    output logic [7:0]       byte_o
);
    localparam int ARG_BYTES = ARG_W / 8;

    logic [7:0] arg_b [ARG_BYTES];

    // Split the argument into bytes, most significant first.
    generate
        for (genvar g = 0; g < ARG_BYTES; g++) begin : g_argb
            assign arg_b[g] = arg[ARG_W-1-8*g -: 8];
        end
    endgenerate

    // Pick prefix+index, argument byte, trailing byte or filler.
    always_comb begin
        byte_o = FILL_BYTE;
        if (pos == '0) begin
            byte_o = CMD_PREFIX | {2'b00, idx};
        end else if (int'(pos) <= ARG_BYTES) begin
            byte_o = arg_b[int'(pos) - 1];
        end else if (int'(pos) == ARG_BYTES + 1) begin
            byte_o = tail;
        end
    end
endmodule

// File: rtl/sd_token_detect.sv
// Classifies each received byte against the three block data tokens.
// The result is held until the next received byte.
module sd_token_detect
    import sd_frm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_valid,
    input  logic [7:0] rx_byte,
    output tok_kind_t kind
);
    // Update the class on every received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= TOK_NONE;
        end else if (rx_valid) begin
            case (rx_byte)
                TOKEN_SINGLE: kind <= TOK_SINGLE;
                TOKEN_MULTI:  kind <= TOK_MULTI;
                TOKEN_STOP:   kind <= TOK_STOP;
                default:      kind <= TOK_NONE;
            endcase
        end
    end

    p_tok_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_byte == TOKEN_SINGLE |=> kind == TOK_SINGLE);
    p_tok_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_byte == TOKEN_STOP |=> kind == TOK_STOP);
    p_tok_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(kind));
endmodule

// File: rtl/sd_cmd_framer.sv
// Sends one SD command frame in SPI mode and polls for the one-byte reply.
// Assumes the byte engine answers each accepted byte with exactly one
// rx_valid pulse, never in the same cycle the byte is offered.
module sd_cmd_framer
    import sd_frm_pkg::*;
#(
    parameter int POLL_MAX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [5:0] cmd_idx,
    input  logic [31:0] cmd_arg,
    input  logic [7:0] cmd_tail,
    output logic       busy,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_byte,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       done,
    output logic [7:0] resp,
    output logic       timeout,
    output logic [1:0] token_kind
);
    localparam int POS_W  = $clog2(FRAME_LEN + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam logic [POS_W-1:0]  POS_POLL  = POS_W'(FRAME_LEN);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

    frm_state_t        st;
    logic [POS_W-1:0]  pos;
    logic [POLL_W-1:0] polls;
    logic [5:0]        idx_q;
    logic [31:0]       arg_q;
    logic [7:0]        tail_q;
    tok_kind_t         kind;

    sd_frame_mux #(.ARG_W(32), .POS_W(POS_W)) u_mux (
        .pos(pos), .idx(idx_q), .arg(arg_q), .tail(tail_q), .byte_o(tx_byte)
    );

    sd_token_detect u_tok (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .kind(kind)
    );

    assign token_kind = kind;
    assign busy       = (st != ST_IDLE);
    assign tx_valid   = (st == ST_SEND);

    // Sequence frame bytes, filler polling, reply capture and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            pos     <= '0;
            polls   <= '0;
            idx_q   <= '0;
            arg_q   <= '0;
            tail_q  <= '0;
            resp    <= FILL_BYTE;
            timeout <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        idx_q   <= cmd_idx;
                        arg_q   <= cmd_arg;
                        tail_q  <= cmd_tail;
                        pos     <= '0;
                        polls   <= '0;
                        timeout <= 1'b0;
                        st      <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_ready) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rx_valid) begin
                        if (pos != POS_POLL) begin
                            pos <= pos + 1'b1;
                            st  <= ST_SEND;
                        end else if (!rx_byte[7]) begin
                            resp <= rx_byte;
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else if (polls == POLL_LAST) begin
                            resp    <= rx_byte;
                            timeout <= 1'b1;
                            done    <= 1'b1;
                            st      <= ST_IDLE;
                        end else begin
                            polls <= polls + 1'b1;
                            st    <= ST_SEND;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
    p_filler_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && pos == POS_POLL |-> tx_byte == FILL_BYTE);
    p_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !timeout |-> !resp[7]);
    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && timeout |-> resp[7]);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(arg_q) && $stable(idx_q) && $stable(tail_q));
    p_one_outst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_valid);
endmodule

// File: tb/tb_sd_cmd_framer.sv
`timescale 1ns/1ps
module tb_sd_cmd_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic [7:0] cmd_tail = '0;
    logic       busy, tx_valid, done, timeout;
    logic       tx_ready = 1'b1;
    logic [7:0] tx_byte, resp;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [1:0] token_kind;

    int errors = 0;
    int checks = 0;

    // engine model controls
    logic [7:0] log_b [0:31];
    int         nlog = 0;
    bit         pend = 0;
    logic [7:0] next_rx = '0;
    bit         stall = 0;
    bit         phase = 0;
    logic [7:0] frame_reply = 8'h00;
    int         reply_at = 99;
    logic [7:0] reply_val = 8'h00;
    logic [7:0] fill_val = 8'hFF;

    always #2 clk = ~clk;

    sd_cmd_framer #(.POLL_MAX(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .cmd_tail(cmd_tail), .busy(busy),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .done(done), .resp(resp),
        .timeout(timeout), .token_kind(token_kind)
    );

    // Byte engine model: accepts one byte, answers it one cycle later.
    always @(negedge clk) begin
        phase    = ~phase;
        tx_ready = stall ? phase : 1'b1;
        rx_valid = 1'b0;
        if (pend) begin
            rx_valid = 1'b1;
            rx_byte  = next_rx;
            pend     = 0;
        end else if (tx_valid && tx_ready) begin
            if (nlog < 32) log_b[nlog] = tx_byte;
            if (nlog < 6) next_rx = frame_reply;
            else if (nlog - 6 == reply_at) next_rx = reply_val;
            else next_rx = fill_val;
            nlog = nlog + 1;
            pend = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] tok_of(input logic [7:0] b);
        case (b)
            8'hFE:   return 2'd1;
            8'hFC:   return 2'd2;
            8'hFD:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // Run one command and check frame, reply, timeout, done and token.
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic [7:0] tail, input bit poke);
        int cyc;
        int exp_n;
        logic [7:0] exp_resp;
        bit exp_to;
        nlog = 0;
        @(negedge clk);
        cmd_idx = idx; cmd_arg = arg; cmd_tail = tail; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            cmd_idx = ~idx; cmd_arg = ~arg; cmd_tail = ~tail; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R7 done reached", done, 1);
        if (reply_at < 8) begin
            exp_n = 7 + reply_at; exp_resp = reply_val; exp_to = 0;
        end else begin
            exp_n = 14; exp_resp = fill_val; exp_to = 1;
        end
        chk(log_b[0] == (8'h40 + {2'b00, idx}), "R2 command byte", log_b[0], 8'h40 + idx);
        for (int k = 0; k < 4; k++)
            chk(log_b[k+1] == arg[31-8*k -: 8], "R3 argument byte", log_b[k+1], arg[31-8*k -: 8]);
        chk(log_b[5] == tail, "R4 trailing byte", log_b[5], tail);
        for (int k = 6; k < exp_n && k < 32; k++)
            chk(log_b[k] == 8'hFF, "R5 filler byte", log_b[k], 8'hFF);
        chk(nlog == exp_n, "R6 bytes sent", nlog, exp_n);
        chk(resp == exp_resp, "R6 reply value", resp, exp_resp);
        chk(timeout == exp_to, "R7 timeout flag", timeout, exp_to);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        chk(token_kind == tok_of(exp_resp), "R10 token class", token_kind, tok_of(exp_resp));
        @(negedge clk);
        chk(done == 1'b0, "R8 done one clock", done, 0);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(busy == 1'b0 && nlog == exp_n, "R9 start while busy ignored", nlog, exp_n);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] idx_list [8];
        idx_list = '{6'd0, 6'd16, 6'd17, 6'd23, 6'd24, 6'd41, 6'd55, 6'd63};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && tx_valid == 0, "R1 reset idle", {busy, tx_valid}, 0);
        chk(done == 0 && timeout == 0, "R1 reset flags", {done, timeout}, 0);
        chk(token_kind == 2'd0, "R1 reset token", token_kind, 0);

        // R2..R8, R11: sweep index and reply position
        for (int i = 0; i < 8; i++) begin
            for (int ra = 0; ra <= 8; ra++) begin
                stall       = ra[0];
                frame_reply = (i % 2 == 0) ? 8'h00 : 8'hFE;
                fill_val    = 8'hFF;
                reply_at    = (ra == 8) ? 99 : ra;
                reply_val   = 8'((ra * 9 + i * 5)) & 8'h7F;
                run_cmd(idx_list[i], 32'h1234_5678 ^ (i * 32'h0101_0F0F) ^ ra,
                        8'(i * 37 + ra * 3) | 8'h01, 1'b0);
            end
        end

        // R7, R10: timeouts with each token and near-miss filler values
        begin
            logic [7:0] fills [6];
            fills = '{8'hFE, 8'hFC, 8'hFD, 8'hFF, 8'h80, 8'hF0};
            for (int f = 0; f < 6; f++) begin
                stall = f[0];
                frame_reply = 8'h01;
                fill_val = fills[f];
                reply_at = 99;
                run_cmd(6'(f * 7), 32'hA5A5_0000 + f, 8'h95, 1'b0);
            end
        end

        // R9: start pulse while busy
        stall = 1; fill_val = 8'hFF; reply_at = 3; reply_val = 8'h05; frame_reply = 8'h00;
        run_cmd(6'd17, 32'hDEAD_BEEF, 8'h87, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule